// File: doc/BRIEF.md
# Serial Gain-Control Register Interface

This block is the control front end of a programmable-gain amplifier. An external controller sends 12-bit words over a three-wire serial link: a serial clock, serial data and an active-low select. The block decodes each word into a register address and a data byte. A word aimed at the power/gain register updates a pending (shadow) copy of a 2-bit power code and a 6-bit gain code. The amplifier only sees these codes on the active outputs, and they change only when the transmit-enable input falls from high to low. The codes therefore never change in the middle of a burst.

All serial pins and transmit enable are brought into the system clock domain through synchronizer chains before any edge is detected. After reset, a power-up timer runs for a parameterized number of system clocks. Any word that completes before the timer expires is dropped. The block also drives a transmit-disable flag while transmit enable is low, so that the output stage can power down.

Top module: `pgactl_top`

## Requirements
- R1: After reset, `gain_code` and `power_code` are zero and `tx_disable` is 1.
- R2: A word is 12 bits, shifted most significant bit first. Bits 11:8 are the address and bits 7:0 are the data. For address 0 (power/gain), data bits 7:6 are the power code and bits 5:0 are the gain code.
- R3: A power/gain write changes neither output code until the next high-to-low transition of `txen`, whatever the level of `txen` when the write arrives.
- R4: A falling `txen` copies the shadow power and gain codes to the outputs. A rising `txen` leaves the outputs unchanged.
- R5: A word is committed on the rising edge of `cs_n` only when exactly 12 serial clock rising edges were seen while `cs_n` was low. Words of 11 or 13 bits are discarded.
- R6: Words with addresses 2 through 15 change no register.
- R7: A word to address 1 (initialize, written as all zeros) leaves the power and gain codes unchanged.
- R8: A word that completes within `PWRUP_CYCLES` system clocks after reset is ignored.
- R9: `tx_disable` is 1 while the synchronized `txen` is low and 0 while it is high.
- R10: All 64 gain codes are accepted with every power code, including gain 63 with power code 3.
- R11: Serial clock edges while `cs_n` is high are not counted toward a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock; data is sampled on its rising edge |
| sdi | input | 1 | Serial data, MSB first |
| cs_n | input | 1 | Active-low word select; its rising edge commits the word |
| txen | input | 1 | Transmit enable; a falling edge loads the shadow codes |
| gain_code | output | 6 | Active gain code, 1 dB per step |
| power_code | output | 2 | Active bias/power code |
| tx_disable | output | 1 | High while transmit is disabled |

## Verification
The bench sends a word early, while the power-up window is still open. A design that ignored the lockout would show those codes after the next `txen` fall. It writes both while `txen` is low and while it is high, then toggles `txen` in each direction. A design that loaded on the rising edge or wrote straight through would show new codes too early. It sends words of 11 and 13 bits, unused addresses, the initialize word, and stray serial clocks with select high. A bad bit counter or a loose address decode would then corrupt the held codes. An asymmetric data byte and the all-ones byte expose reversed bit order and lost boundary values.

// File: rtl/pgactl_pkg.sv
package pgactl_pkg;
  localparam int PG_ADDR   = 0;
  localparam int INIT_ADDR = 1;
endpackage

// File: rtl/pgactl_sync.sv
module pgactl_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pgactl_frame_rx.sv
module pgactl_frame_rx #(
  parameter int FRAME_BITS = 12,
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              sdi_s,
  input  logic              csn_s,
  output logic              frame_stb,
  output logic [ADDR_W-1:0] frame_addr,
  output logic [DATA_W-1:0] frame_data
);
  localparam int CNT_W = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_BITS + 1);

  logic                  sclk_d, csn_d;
  logic [FRAME_BITS-1:0] shreg;
  logic [CNT_W-1:0]      cnt;
  logic                  stb_q;
  logic [ADDR_W-1:0]     addr_q;
  logic [DATA_W-1:0]     data_q;
  logic                  sclk_rise, cs_fall, cs_rise;

  assign sclk_rise = sclk_s & ~sclk_d;
  assign cs_fall   = ~csn_s & csn_d;
  assign cs_rise   = csn_s & ~csn_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      csn_d  <= 1'b1;
      shreg  <= '0;
      cnt    <= '0;
      stb_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      sclk_d <= sclk_s;
      csn_d  <= csn_s;
      stb_q  <= 1'b0;
      if (cs_fall) begin
        cnt <= '0;
      end else if (!csn_s && sclk_rise) begin
        shreg <= {shreg[FRAME_BITS-2:0], sdi_s};
        if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
      end
      if (cs_rise) begin
        stb_q  <= (cnt == CNT_FULL);
        addr_q <= shreg[FRAME_BITS-1 -: ADDR_W];
        data_q <= shreg[DATA_W-1:0];
      end
    end
  end

  assign frame_stb  = stb_q;
  assign frame_addr = addr_q;
  assign frame_data = data_q;

  AST_BITCNT_SAT: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_OVER); // R5
  AST_STB_FULL_ONLY: assert property (@(posedge clk) disable iff (rst)
    stb_q |-> $past(cnt) == CNT_FULL); // R5
endmodule

// File: rtl/pgactl_pwrup_timer.sv
module pgactl_pwrup_timer #(
  parameter int PWRUP_CYCLES = 10000
) (
  input  logic clk,
  input  logic rst,
  output logic ready
);
  localparam int CNT_W = $clog2(PWRUP_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PWRUP_CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic             ready_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      ready_q <= 1'b0;
    end else if (!ready_q) begin
      if (cnt == LAST) ready_q <= 1'b1;
      else             cnt     <= cnt + 1'b1;
    end
  end

  assign ready = ready_q;

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst)
    ready_q |=> ready_q); // R8
endmodule

// File: rtl/pgactl_ctrl_regs.sv
module pgactl_ctrl_regs
  import pgactl_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int GAIN_W = 6,
  parameter int PWR_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ready,
  input  logic              frame_stb,
  input  logic [ADDR_W-1:0] frame_addr,
  input  logic [DATA_W-1:0] frame_data,
  input  logic              txen_s,
  output logic [GAIN_W-1:0] gain_code,
  output logic [PWR_W-1:0]  power_code,
  output logic              tx_disable
);
  localparam logic [ADDR_W-1:0] A_PG   = ADDR_W'(PG_ADDR);
  localparam logic [ADDR_W-1:0] A_INIT = ADDR_W'(INIT_ADDR);

  logic              txen_d, txen_fall, wr_pg;
  logic [GAIN_W-1:0] sh_gain, act_gain;
  logic [PWR_W-1:0]  sh_pwr, act_pwr;
  logic              txdis_q;

  assign txen_fall = txen_d & ~txen_s;
  assign wr_pg     = frame_stb && ready && (frame_addr == A_PG);

  always_ff @(posedge clk) begin
    if (rst) begin
      txen_d   <= 1'b0;
      sh_gain  <= '0;
      sh_pwr   <= '0;
      act_gain <= '0;
      act_pwr  <= '0;
      txdis_q  <= 1'b1;
    end else begin
      txen_d  <= txen_s;
      txdis_q <= ~txen_s;
      if (wr_pg) begin
        sh_pwr  <= frame_data[DATA_W-1 -: PWR_W];
        sh_gain <= frame_data[GAIN_W-1:0];
      end
      if (txen_fall) begin
        act_gain <= sh_gain;
        act_pwr  <= sh_pwr;
      end
    end
  end

  assign gain_code  = act_gain;
  assign power_code = act_pwr;
  assign tx_disable = txdis_q;

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !txen_fall |=> $stable(act_gain) && $stable(act_pwr)); // R3
  AST_LOCKOUT: assert property (@(posedge clk) disable iff (rst)
    (frame_stb && !ready) |=> $stable(sh_gain) && $stable(sh_pwr)); // R8
  AST_UNUSED_ADDR: assert property (@(posedge clk) disable iff (rst)
    (frame_stb && frame_addr > A_INIT) |=> $stable(sh_gain) && $stable(sh_pwr)); // R6
  AST_INIT_NOWRITE: assert property (@(posedge clk) disable iff (rst)
    (frame_stb && frame_addr == A_INIT) |=> $stable(sh_gain) && $stable(sh_pwr)); // R7
endmodule

// File: rtl/pgactl_top.sv
module pgactl_top #(
  parameter int FRAME_BITS   = 12,
  parameter int ADDR_W       = 4,
  parameter int DATA_W       = 8,
  parameter int GAIN_W       = 6,
  parameter int PWR_W        = 2,
  parameter int SYNC_STAGES  = 2,
  parameter int PWRUP_CYCLES = 10000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              cs_n,
  input  logic              txen,
  output logic [GAIN_W-1:0] gain_code,
  output logic [PWR_W-1:0]  power_code,
  output logic              tx_disable
);
  localparam int NSYNC = 4;
  localparam logic [NSYNC-1:0] SYNC_RST = 4'b0100;

  logic [NSYNC-1:0]  raw_in, syn_out;
  logic              frame_stb, ready;
  logic [ADDR_W-1:0] frame_addr;
  logic [DATA_W-1:0] frame_data;

  assign raw_in = {txen, cs_n, sdi, sclk};

  for (genvar i = 0; i < NSYNC; i++) begin : g_sync
    pgactl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST[i])) u_sync (
      .clk(clk), .rst(rst), .d(raw_in[i]), .q(syn_out[i])
    );
  end

  pgactl_frame_rx #(.FRAME_BITS(FRAME_BITS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst(rst),
    .sclk_s(syn_out[0]), .sdi_s(syn_out[1]), .csn_s(syn_out[2]),
    .frame_stb(frame_stb), .frame_addr(frame_addr), .frame_data(frame_data)
  );

  pgactl_pwrup_timer #(.PWRUP_CYCLES(PWRUP_CYCLES)) u_tmr (
    .clk(clk), .rst(rst), .ready(ready)
  );

  pgactl_ctrl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .GAIN_W(GAIN_W), .PWR_W(PWR_W)) u_regs (
    .clk(clk), .rst(rst), .ready(ready),
    .frame_stb(frame_stb), .frame_addr(frame_addr), .frame_data(frame_data),
    .txen_s(syn_out[3]),
    .gain_code(gain_code), .power_code(power_code), .tx_disable(tx_disable)
  );
endmodule

// File: tb/sim_pgactl_top.sv
module sim_pgactl_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sdi = 1'b0, cs_n = 1'b1, txen = 1'b0;
  logic [5:0] gain_code;
  logic [1:0] power_code;
  logic       tx_disable;

  typedef struct {
    string      tag;
    logic [5:0] g;
    logic [1:0] p;
    logic       d;
  } exp_t;

  exp_t q[$];
  int nvec = 0;
  int nbad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pgactl_top #(.PWRUP_CYCLES(400)) u0 (
    .clk(clk), .rst(rst), .sclk(sclk), .sdi(sdi), .cs_n(cs_n), .txen(txen),
    .gain_code(gain_code), .power_code(power_code), .tx_disable(tx_disable)
  );

  // monitor: pops expected items and compares them with the outputs
  initial begin
    exp_t e;
    forever begin
      wait (q.size() != 0);
      e = q.pop_front();
      nvec++;
      if (gain_code !== e.g || power_code !== e.p || tx_disable !== e.d) begin
        nbad++;
        $display("FAIL %s: got g=%0d p=%0d dis=%0b, expected g=%0d p=%0d dis=%0b",
                 e.tag, gain_code, power_code, tx_disable, e.g, e.p, e.d);
      end
    end
  end

  task automatic expect_out(string tag, logic [5:0] g, logic [1:0] p, logic d);
    exp_t e;
    repeat (8) @(negedge clk);
    e.tag = tag; e.g = g; e.p = p; e.d = d;
    q.push_back(e);
  endtask

  task automatic send_bits(int n, logic [15:0] w);
    @(negedge clk);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = w[i];
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic write_reg(logic [3:0] a, logic [7:0] d);
    send_bits(12, {4'h0, a, d});
  endtask

  task automatic txen_set(logic v);
    @(negedge clk);
    txen = v;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    expect_out("R1 reset", 6'd0, 2'd0, 1'b1);
    // early write inside the power-up window
    write_reg(4'h0, 8'hFF);
    repeat (400) @(negedge clk);
    txen_set(1'b1);
    expect_out("R9 txen high", 6'd0, 2'd0, 1'b0);
    txen_set(1'b0);
    expect_out("R8 lockout", 6'd0, 2'd0, 1'b1);
    // write while txen low, data 0xA5 -> power 2, gain 37
    write_reg(4'h0, 8'hA5);
    expect_out("R3 no early update", 6'd0, 2'd0, 1'b1);
    txen_set(1'b1);
    expect_out("R4 rising edge no load", 6'd0, 2'd0, 1'b0);
    txen_set(1'b0);
    expect_out("R4 falling edge load", 6'd37, 2'd2, 1'b1);
    // write while txen high, boundary values
    txen_set(1'b1);
    write_reg(4'h0, 8'hFF);
    expect_out("R3 held while high", 6'd37, 2'd2, 1'b0);
    txen_set(1'b0);
    expect_out("R10 gain63 power3", 6'd63, 2'd3, 1'b1);
    // short and long words
    send_bits(11, 16'h0012);
    txen_set(1'b1); txen_set(1'b0);
    expect_out("R5 11-bit discarded", 6'd63, 2'd3, 1'b1);
    send_bits(13, 16'h0012);
    txen_set(1'b1); txen_set(1'b0);
    expect_out("R5 13-bit discarded", 6'd63, 2'd3, 1'b1);
    // unused addresses
    write_reg(4'h3, 8'h00);
    write_reg(4'hF, 8'h11);
    txen_set(1'b1); txen_set(1'b0);
    expect_out("R6 unused address", 6'd63, 2'd3, 1'b1);
    // initialize register
    write_reg(4'h1, 8'h00);
    txen_set(1'b1); txen_set(1'b0);
    expect_out("R7 init no change", 6'd63, 2'd3, 1'b1);
    // bit order: 0x86 -> power 2, gain 6
    write_reg(4'h0, 8'h86);
    txen_set(1'b1); txen_set(1'b0);
    expect_out("R2 msb first", 6'd6, 2'd2, 1'b1);
    // stray serial clocks with select high, then a valid word
    for (int k = 0; k < 3; k++) begin
      repeat (4) @(negedge clk); sclk = 1'b1;
      repeat (4) @(negedge clk); sclk = 1'b0;
    end
    write_reg(4'h0, 8'h40);
    txen_set(1'b1); txen_set(1'b0);
    expect_out("R11 idle clocks ignored", 6'd0, 2'd1, 1'b1);
    write_reg(4'h0, 8'h01);
    txen_set(1'b1); txen_set(1'b0);
    expect_out("R2 gain lsb", 6'd1, 2'd0, 1'b1);
    wait (q.size() == 0);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule